// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Stick Parity

This block turns bytes written on a parallel strobe port into asynchronous serial frames on one output line. A frame is a low start bit, eight data bits sent least significant bit first, an optional parity bit, and a high stop bit. Each bit lasts a fixed number of pulses of an external baud tick. Between frames the line rests high.

Writes go to a queue whose capacity is chosen at run time. With the queue control set, the writes fill a multi-entry first-in first-out buffer. With it cleared, they fill a single holding slot. The parity bit is set by three controls: an enable, an even/odd selector, and a stick selector. The stick selector replaces the computed parity with a constant. A break control pulls the line low at once and abandons the frame in flight. When break is released, sending restarts with the next queued byte.

Top module: `serial_tx_core`

## Requirements
- R1: After reset the line `txd` is 1, and `busy` and `full` are 0. An idle line stays at 1. Each frame sends a start bit of 0, then `wr_data[0]` through `wr_data[7]` in that order, then a stop bit of 1.
- R2: Every bit of a frame lasts exactly `TICKS_PER_BIT` cycles in which `baud_tick` is 1. While `baud_tick` stays 0 the line does not advance.
- R3: With `par_en` = 0 there is no parity bit, and the stop bit follows data bit 7 directly. `par_even` and `par_stick` then have no effect on the line.
- R4: With `par_en` = 1, `par_stick` = 0 and `par_even` = 0, the parity bit follows data bit 7. It makes the number of ones across the data and parity bits odd.
- R5: With `par_en` = 1, `par_stick` = 0 and `par_even` = 1, the parity bit makes that number of ones even.
- R6: With `par_en` = 1 and `par_stick` = 1, the parity bit is 1 when `par_even` = 0 and 0 when `par_even` = 1, whatever the data.
- R7: While `brk` is 1, `txd` is 0, starting in the same cycle even in the middle of a frame. The frame in flight is abandoned, and no queued byte is started.
- R8: After `brk` falls, the next frame carries the next queued byte. The abandoned byte is never sent again.
- R9: With `fifo_en` = 1 the queue holds `FIFO_DEPTH` bytes. `full` rises when the last slot is taken. A write while `full` is 1 is dropped, and bytes leave in the order written.
- R10: With `fifo_en` = 0 the queue holds a single byte. `full` is 1 while that slot is occupied, and further writes are dropped.
- R11: `busy` is 1 while a frame is on the line or a byte is queued, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to queue |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | 1 = even parity, 0 = odd parity; with stick: selects the constant |
| par_stick | input | 1 | Send a constant parity bit |
| fifo_en | input | 1 | 1 = multi-entry queue, 0 = single holding slot |
| brk | input | 1 | Force the line low and abandon the current frame |
| baud_tick | input | 1 | Bit-timing pulse |
| txd | output | 1 | Serial output line |
| busy | output | 1 | Frame in progress or byte queued |
| full | output | 1 | Queue cannot accept a write |

## Verification
The bench builds the block with `FIFO_DEPTH` = 4 and `TICKS_PER_BIT` = 4. These values make each frame short enough to sweep all 256 byte values under every parity setting. They also let the queue be filled to overflow in a handful of writes, in both capacity modes. A run with the baud tick gated to every other cycle, and a run with the tick held off, show that bit length follows the tick and not the clock. Break is asserted in the middle of a frame, with a second byte waiting behind it.

// File: rtl/stx_pkg.sv
package stx_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_SEND = 1'b1
   } stx_state_e;

   typedef struct packed {
      logic en;
      logic even;
      logic stick;
   } stx_par_cfg_t;

endpackage

// File: rtl/stx_queue.sv
module stx_queue #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pop,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              full
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("stx_queue: DEPTH must be at least 2");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  count;
   logic              accept;

   // Pointer advance: free wrap for power-of-two depths, compare otherwise.
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   // Capacity depends on the mode: all slots, or only one.
   assign empty   = (count == '0);
   assign full    = fifo_en ? (count == CNT_MAX) : !empty;
   assign accept  = wr_en && !full;
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (accept) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (accept) wr_ptr <= wr_nxt;
         if (pop)    rd_ptr <= rd_nxt;
         unique case ({accept, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_MAX); // R9
   AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !pop) |=> (count == $past(count))); // R9
   AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty); // R8
   AST_HOLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!fifo_en && $past(!fifo_en) && $past(empty)) |-> (count <= CNT_W'(1))); // R10

endmodule

// File: rtl/stx_parity_sel.sv
module stx_parity_sel #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0]   data,
   input  stx_pkg::stx_par_cfg_t cfg,
   output logic                par_bit
);
   logic ones_odd;

   // Reduction built bit by bit so the width follows DATA_W.
   logic [DATA_W-1:0] chain;
   for (genvar i = 0; i < DATA_W; i++) begin : g_xor
      if (i == 0) begin : g_first
         assign chain[i] = data[i];
      end else begin : g_next
         assign chain[i] = chain[i-1] ^ data[i];
      end
   end
   assign ones_odd = chain[DATA_W-1];

   always_comb begin
      if (cfg.stick)      par_bit = !cfg.even;
      else if (cfg.even)  par_bit = ones_odd;
      else                par_bit = !ones_odd;
   end

endmodule

// File: rtl/stx_frame_shift.sv
module stx_frame_shift #(
   parameter int DATA_W        = 8,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              brk,
   input  logic              baud_tick,
   input  logic              avail,
   input  logic [DATA_W-1:0] data,
   input  logic              par_en,
   input  logic              par_bit,
   output logic              pop,
   output logic              line,
   output logic              active
);
   import stx_pkg::*;

   localparam int FRM_W  = DATA_W + 3;
   localparam int TCNT_W = $clog2(TICKS_PER_BIT);
   localparam int BIT_W  = $clog2(FRM_W + 1);
   localparam logic [TCNT_W-1:0] TCNT_LAST = TCNT_W'(TICKS_PER_BIT - 1);

   if (TICKS_PER_BIT < 2) begin : g_bad_tpb
      $error("stx_frame_shift: TICKS_PER_BIT must be at least 2");
   end

   stx_state_e        st;
   logic [FRM_W-1:0]  sr;
   logic [TCNT_W-1:0] tcnt;
   logic [BIT_W-1:0]  bidx;
   logic [BIT_W-1:0]  flen;
   logic              bit_end;
   logic              last_bit;

   assign pop      = (st == ST_IDLE) && !brk && avail;
   assign bit_end  = baud_tick && (tcnt == TCNT_LAST);
   assign last_bit = (bidx == flen - 1'b1);
   assign active   = (st == ST_SEND);
   assign line     = active ? sr[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         sr   <= '1;
         tcnt <= '0;
         bidx <= '0;
         flen <= BIT_W'(FRM_W - 1);
      end else if (brk) begin
         st   <= ST_IDLE;
         sr   <= '1;
         tcnt <= '0;
         bidx <= '0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (avail) begin
                  st   <= ST_SEND;
                  tcnt <= '0;
                  bidx <= '0;
                  if (par_en) begin
                     sr   <= {1'b1, par_bit, data, 1'b0};
                     flen <= BIT_W'(FRM_W);
                  end else begin
                     sr   <= {1'b1, 1'b1, data, 1'b0};
                     flen <= BIT_W'(FRM_W - 1);
                  end
               end
            end
            ST_SEND: begin
               if (baud_tick) begin
                  if (bit_end) begin
                     tcnt <= '0;
                     sr   <= {1'b1, sr[FRM_W-1:1]};
                     if (last_bit) begin
                        st   <= ST_IDLE;
                        bidx <= '0;
                     end else begin
                        bidx <= bidx + 1'b1;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_BRK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      brk |=> !active); // R7
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> !line); // R1
   AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (active && bit_end && last_bit) |-> line); // R1
   AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !baud_tick && !brk) |=> $stable(line)); // R2

endmodule

// File: rtl/serial_tx_core.sv
module serial_tx_core #(
   parameter int DATA_W        = 8,
   parameter int FIFO_DEPTH    = 16,
   parameter int TICKS_PER_BIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              par_en,
   input  logic              par_even,
   input  logic              par_stick,
   input  logic              fifo_en,
   input  logic              brk,
   input  logic              baud_tick,
   output logic              txd,
   output logic              busy,
   output logic              full
);
   import stx_pkg::*;

   if (DATA_W < 1) begin : g_bad_width
      $error("serial_tx_core: DATA_W must be positive");
   end

   logic [DATA_W-1:0] head;
   logic              q_empty;
   logic              q_pop;
   logic              par_bit;
   logic              line;
   logic              active;
   stx_par_cfg_t      pcfg;

   assign pcfg = '{en: par_en, even: par_even, stick: par_stick};

   stx_queue #(
      .DATA_W (DATA_W),
      .DEPTH  (FIFO_DEPTH)
   ) u_queue (
      .clk     (clk),
      .rst_n   (rst_n),
      .fifo_en (fifo_en),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .pop     (q_pop),
      .rd_data (head),
      .empty   (q_empty),
      .full    (full)
   );

   stx_parity_sel #(
      .DATA_W (DATA_W)
   ) u_parity (
      .data    (head),
      .cfg     (pcfg),
      .par_bit (par_bit)
   );

   stx_frame_shift #(
      .DATA_W        (DATA_W),
      .TICKS_PER_BIT (TICKS_PER_BIT)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .brk       (brk),
      .baud_tick (baud_tick),
      .avail     (!q_empty),
      .data      (head),
      .par_en    (pcfg.en),
      .par_bit   (par_bit),
      .pop       (q_pop),
      .line      (line),
      .active    (active)
   );

   assign txd  = brk ? 1'b0 : line;
   assign busy = active || !q_empty;

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !brk) |-> txd); // R1
   AST_BRK_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (brk && !active) |=> !active); // R7

endmodule

// File: tb/tb_serial_tx_core.sv
module tb_serial_tx_core;
   localparam int DW  = 8;
   localparam int DEP = 4;
   localparam int TPB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
   logic          fifo_en = 1'b1, brk = 1'b0, baud_tick = 1'b0;
   logic          txd, busy, full;
   int            tick_mode = 0;
   int            n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   always @(negedge clk) begin
      if (tick_mode == 0)      baud_tick <= 1'b1;
      else if (tick_mode == 1) baud_tick <= ~baud_tick;
      else                     baud_tick <= 1'b0;
   end

   serial_tx_core #(
      .DATA_W (DW), .FIFO_DEPTH (DEP), .TICKS_PER_BIT (TPB)
   ) dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
      .par_en (par_en), .par_even (par_even), .par_stick (par_stick),
      .fifo_en (fifo_en), .brk (brk), .baud_tick (baud_tick),
      .txd (txd), .busy (busy), .full (full)
   );

   task automatic chk(input logic ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Receives one frame and compares it with the value computed from the rules.
   task automatic expect_frame(input logic [DW-1:0] d, input logic pe, input logic ev,
                               input logic sk, input int bc, input logic tail,
                               input string req);
      int            w = 0;
      logic [DW-1:0] got_d;
      logic          got_s0, got_p, got_stop, got_t, busy_mid, exp_p;
      int            ones;
      do begin
         @(negedge clk); w++;
      end while (txd !== 1'b0 && w < 2000);
      if (w >= 2000) begin
         chk(1'b0, req, "no start bit", 32'(txd), 32'h0);
         return;
      end
      repeat (bc/2) @(negedge clk);
      got_s0 = txd; busy_mid = busy;
      for (int k = 0; k < DW; k++) begin
         repeat (bc) @(negedge clk);
         got_d[k] = txd;
      end
      got_p = 1'b1;
      if (pe) begin
         repeat (bc) @(negedge clk);
         got_p = txd;
      end
      repeat (bc) @(negedge clk);
      got_stop = txd;
      ones  = $countones(d);
      exp_p = sk ? ~ev : (ev ? ((ones % 2) == 1) : ((ones % 2) == 0));
      chk(got_s0 == 1'b0 && got_d == d && got_stop == 1'b1 && (!pe || got_p == exp_p),
          req, "frame {stop,par,data,start}",
          {21'h0, got_stop, got_p, got_d, got_s0},
          {21'h0, 1'b1, pe ? exp_p : 1'b1, d, 1'b0});
      if (tail) begin
         repeat (bc) @(negedge clk);
         got_t = txd;
         chk(got_t == 1'b1 && busy == 1'b0 && busy_mid == 1'b1, "R11",
             "idle after frame {txd,busy,busy_mid}",
             {29'h0, got_t, busy, busy_mid}, 32'h5);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(txd == 1'b1 && busy == 1'b0 && full == 1'b0, "R1", "reset {txd,busy,full}",
          {29'h0, txd, busy, full}, 32'h4);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 R3 R4 R5 R6: every byte under each parity setting
      for (int m = 0; m < 5; m++) begin
         par_en    = (m != 0);
         par_even  = (m == 2) || (m == 4);
         par_stick = (m >= 3);
         for (int b = 0; b < 256; b++) begin
            put(8'(b));
            expect_frame(8'(b), par_en, par_even, par_stick, TPB, 1'b1,
                         m == 0 ? "R3" : m == 1 ? "R4" : m == 2 ? "R5" : "R6");
         end
      end

      // R3: even and stick selectors ignored while parity is off
      par_en = 1'b0;
      for (int c = 1; c < 4; c++) begin
         par_even = c[0]; par_stick = c[1];
         for (int b = 0; b < 16; b++) begin
            put(8'(b * 17 + c));
            expect_frame(8'(b * 17 + c), 1'b0, par_even, par_stick, TPB, 1'b1, "R3");
         end
      end

      // R2: tick every other cycle doubles bit length
      tick_mode = 1;
      par_en = 1'b1; par_even = 1'b1; par_stick = 1'b0;
      for (int b = 0; b < 6; b++) begin
         put(8'(8'h5A + b * 29));
         expect_frame(8'(8'h5A + b * 29), 1'b1, 1'b1, 1'b0, 2 * TPB, 1'b1, "R2");
      end

      // R2: no tick, no progress
      tick_mode = 2;
      put(8'hFF);
      repeat (30) @(negedge clk);
      chk(txd == 1'b0 && busy == 1'b1, "R2", "stalled start {txd,busy}",
          {30'h0, txd, busy}, 32'h1);
      tick_mode = 0;
      expect_frame(8'hFF, 1'b1, 1'b1, 1'b0, TPB, 1'b1, "R2");

      // R7 R8: break in the middle of a frame with a byte waiting
      par_en = 1'b0; par_even = 1'b0; par_stick = 1'b0;
      put(8'hA5);
      put(8'h3C);
      while (txd !== 1'b0) @(negedge clk);
      repeat (10) @(negedge clk);
      brk = 1'b1;
      #1;
      chk(txd == 1'b0, "R7", "line at break", 32'(txd), 32'h0);
      begin
         int highs = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd !== 1'b0) highs++;
         end
         chk(highs == 0, "R7", "high samples during break", 32'(highs), 32'h0);
      end
      chk(busy == 1'b1, "R11", "busy with byte queued in break", 32'(busy), 32'h1);
      brk = 1'b0;
      expect_frame(8'h3C, 1'b0, 1'b0, 1'b0, TPB, 1'b1, "R8");

      // R10: single holding slot
      fifo_en = 1'b0;
      brk = 1'b1;
      put(8'h11);
      chk(full == 1'b1, "R10", "full after one write", 32'(full), 32'h1);
      put(8'h22);
      brk = 1'b0;
      expect_frame(8'h11, 1'b0, 1'b0, 1'b0, TPB, 1'b1, "R10");
      chk(full == 1'b0, "R10", "full after drain", 32'(full), 32'h0);

      // R9: multi-entry queue to overflow
      fifo_en = 1'b1;
      brk = 1'b1;
      for (int i = 0; i < DEP - 1; i++) put(8'(8'hC0 + i));
      chk(full == 1'b0, "R9", "full one short of depth", 32'(full), 32'h0);
      put(8'(8'hC0 + DEP - 1));
      chk(full == 1'b1, "R9", "full at depth", 32'(full), 32'h1);
      put(8'h77);
      brk = 1'b0;
      for (int i = 0; i < DEP; i++)
         expect_frame(8'(8'hC0 + i), 1'b0, 1'b0, 1'b0, TPB, i == DEP - 1, "R9");

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule